// File: doc/BRIEF.md
# Set-Associative Tag Directory with Permission-Qualified Hits

This block keeps the tag and state side of a set-associative cache. For every way of every set it records whether the way is occupied, which line address it holds, a permission state, and the context that owns a lock on the line. It does not store line data. A controller issues one command per cycle against a line-aligned address. The directory answers one cycle later with a success flag, a way number and, for some commands, an address.

The commands are:
- search for a line;
- check an access against the line's permission;
- ask whether the set has room;
- allocate or release a line;
- change a line's permission;
- ask which line would be evicted;
- set, clear or test a line's lock;
- read any way by a flat slot number.

A tag match grants an access only if the stored permission allows the request kind. Any tag match still refreshes the true-LRU order of the set. A command whose precondition does not hold changes nothing and raises a sticky error flag.

Top module: `tagdir_top`

## Requirements
- R1: After reset every way is empty, `err` is 0 and `rsp_valid` is 0. A search then misses and an availability query succeeds.
- R2: The directory has CACHE_BYTES/WAYS/LINE_BYTES sets. The set index is `cmd_addr[INDEX_LSB +: log2(sets)]`. Lines in different sets never affect each other.
- R3: Permission codes are NotPresent=0, Invalid=1, Busy=2, ReadOnly=3, ReadWrite=4. A search (op 1) hits only on an occupied way with an equal address and a permission other than NotPresent. It returns ok=1 and the way.
- R4: An access check (op 2) grants (ok=1) when the matching line is ReadWrite, or when it is ReadOnly and the request kind is load (0) or fetch (1). Store (2) and atomic (3) need ReadWrite. Any other case returns ok=0.
- R5: An access check that finds a tag match makes that way most recent, whether or not the check grants.
- R6: An availability query (op 3) returns ok=1 when some occupied way holds the address, or when some way is empty or NotPresent.
- R7: Allocate (op 4) needs the address absent and a free way. It fills the lowest-numbered empty or NotPresent way, sets Invalid, resets the lock owner to no-owner (all ones) and returns that way. It makes the way most recent only when `cmd_touch` is 1.
- R8: Replacement is true LRU per set. A victim query (op 6) on a set with no room returns ok=1, the least recently touched way and its stored address.
- R9: Lock set (op 8) stores `cmd_ctx` and lock clear (op 9) restores no-owner, both on a present line. Lock test (op 10) returns ok=1 only when the stored owner equals `cmd_ctx`.
- R10: Release (op 5) of a present line empties its way, so a later search misses and the way can be allocated again. Set-permission (op 7) writes `cmd_perm` to a present line. NotPresent makes the way free.
- R11: Slot read (op 11) of slot = set*WAYS+way returns the stored address with ok=1. It returns 0 with ok=0 when the way is empty, Invalid or NotPresent.
- R12: These commands change no state, return ok=0 and set `err`, which stays set until reset:
  - a misaligned address;
  - allocate of a present line or into a full set;
  - release, permission change or lock command on an absent line;
  - a victim query on a set with room;
  - an undefined opcode or permission code.
- R13: Each command with `cmd_valid`=1 and op other than 0 (no-op) gives exactly one response, with `rsp_valid`=1 in the cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Command opcode |
| cmd_addr | input | ADDR_W | Line-aligned address |
| cmd_req | input | 2 | Request kind for access checks |
| cmd_perm | input | 3 | Permission for set-permission |
| cmd_ctx | input | CTX_W | Context for lock set and test |
| cmd_touch | input | 1 | Allocate also refreshes LRU |
| cmd_slot | input | SLOT_W | Flat slot number for slot read |
| rsp_valid | output | 1 | Response present |
| rsp_ok | output | 1 | Success or grant |
| rsp_way | output | WAY_W | Way concerned |
| rsp_addr | output | ADDR_W | Victim or slot address |
| err | output | 1 | Sticky precondition error |

## Verification
Every result, including the error flag, is registered once. It is therefore due exactly one clock after the command is accepted. The bench drives each command on a falling edge and pushes its expected response into a queue at that moment. A monitor pops the queue on every falling edge that shows `rsp_valid`, so each response is compared half a period after the rising edge that produced it. The LRU victims are worked out by hand from the touch history in the command list. The expected error flag is carried in each queued item, so its stickiness is checked on every later response.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;
  typedef enum logic [3:0] {
    OP_NOP      = 4'd0,
    OP_LOOKUP   = 4'd1,
    OP_ACCESS   = 4'd2,
    OP_AVAIL    = 4'd3,
    OP_ALLOC    = 4'd4,
    OP_DEALLOC  = 4'd5,
    OP_PROBE    = 4'd6,
    OP_SETPERM  = 4'd7,
    OP_LOCKSET  = 4'd8,
    OP_LOCKCLR  = 4'd9,
    OP_LOCKTEST = 4'd10,
    OP_READSLOT = 4'd11
  } op_e;

  typedef enum logic [2:0] {
    PERM_NP  = 3'd0,
    PERM_INV = 3'd1,
    PERM_BSY = 3'd2,
    PERM_RO  = 3'd3,
    PERM_RW  = 3'd4
  } perm_e;

  typedef enum logic [1:0] {
    REQ_LOAD   = 2'd0,
    REQ_FETCH  = 2'd1,
    REQ_STORE  = 2'd2,
    REQ_ATOMIC = 2'd3
  } req_e;
endpackage

// File: rtl/tagdir_store.sv
module tagdir_store
  import tagdir_pkg::*;
#(
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int ADDR_W = 32,
  parameter int CTX_W  = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [SET_W-1:0]             set_idx,
  input  logic                         fill_en,
  input  logic                         drop_en,
  input  logic                         perm_en,
  input  logic                         lock_en,
  input  logic [WAY_W-1:0]             wr_way,
  input  logic [ADDR_W-1:0]            fill_addr,
  input  logic [2:0]                   perm_val,
  input  logic [CTX_W-1:0]             lock_val,
  output logic [WAYS-1:0]              way_valid,
  output logic [WAYS-1:0][2:0]         way_perm,
  output logic [WAYS-1:0][ADDR_W-1:0]  way_tag,
  output logic [WAYS-1:0][CTX_W-1:0]   way_lock,
  input  logic [SET_W-1:0]             slot_set,
  input  logic [WAY_W-1:0]             slot_way,
  output logic                         slot_valid,
  output logic [2:0]                   slot_perm,
  output logic [ADDR_W-1:0]            slot_tag
);
  logic [WAYS-1:0]             sv;
  logic [WAYS-1:0][2:0]        sp;
  logic [WAYS-1:0][ADDR_W-1:0] st;

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    logic [ADDR_W-1:0] tag_mem  [SETS];
    logic [CTX_W-1:0]  lock_mem [SETS];
    logic [SETS-1:0]   vld_q;
    logic [2:0]        perm_q   [SETS];
    logic              sel;

    assign sel = (wr_way == WAY_W'(g));

    // RAM-style arrays: no reset, one write port, asynchronous reads
    always_ff @(posedge clk) begin
      if (fill_en && sel) tag_mem[set_idx] <= fill_addr;
      if ((fill_en || lock_en) && sel)
        lock_mem[set_idx] <= fill_en ? {CTX_W{1'b1}} : lock_val;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q <= '0;
        for (int s = 0; s < SETS; s++) perm_q[s] <= PERM_NP;
      end else if (sel) begin
        if (fill_en) begin
          vld_q[set_idx]  <= 1'b1;
          perm_q[set_idx] <= PERM_INV;
        end else if (drop_en) begin
          vld_q[set_idx]  <= 1'b0;
          perm_q[set_idx] <= PERM_NP;
        end else if (perm_en) begin
          perm_q[set_idx] <= perm_val;
        end
      end
    end

    assign way_valid[g] = vld_q[set_idx];
    assign way_perm[g]  = perm_q[set_idx];
    assign way_tag[g]   = tag_mem[set_idx];
    assign way_lock[g]  = lock_mem[set_idx];
    assign sv[g]        = vld_q[slot_set];
    assign sp[g]        = perm_q[slot_set];
    assign st[g]        = tag_mem[slot_set];
  end

  assign slot_valid = sv[slot_way];
  assign slot_perm  = sp[slot_way];
  assign slot_tag   = st[slot_way];

  // R7: a fill may only land on a way that is empty or NotPresent
  p_fill_free_r7: assert property (@(posedge clk) disable iff (rst)
    fill_en |-> (!way_valid[wr_way] || way_perm[wr_way] == PERM_NP));
endmodule

// File: rtl/tagdir_lru.sv
module tagdir_lru #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] set_idx,
  input  logic             touch_en,
  input  logic [WAY_W-1:0] touch_way,
  input  logic [WAYS-1:0]  empty_vec,
  output logic [WAY_W-1:0] victim_way
);
  logic [WAY_W-1:0] age_q [SETS][WAYS];
  logic [WAY_W-1:0] ref_age;

  assign ref_age = age_q[set_idx][touch_way];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          age_q[set_idx][w] <= '0;
        else if (age_q[set_idx][w] < ref_age)
          age_q[set_idx][w] <= age_q[set_idx][w] + 1'b1;
      end
    end
  end

  always_comb begin
    logic found;
    found      = 1'b0;
    victim_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && empty_vec[w]) begin
        victim_way = WAY_W'(w);
        found      = 1'b1;
      end
    end
    if (!found) begin
      for (int w = 0; w < WAYS; w++)
        if (age_q[set_idx][w] == WAY_W'(WAYS - 1)) victim_way = WAY_W'(w);
    end
  end

  logic [WAYS-1:0] seen [SETS];
  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      seen[s] = '0;
      for (int w = 0; w < WAYS; w++)
        seen[s] = seen[s] | (WAYS'(1) << age_q[s][w]);
    end
  end

  for (genvar s = 0; s < SETS; s++) begin : g_chk
    // R8: the ages of one set always form a permutation of 0..WAYS-1
    p_age_perm_r8: assert property (@(posedge clk) disable iff (rst)
      seen[s] == {WAYS{1'b1}});
  end
endmodule

// File: rtl/tagdir_match.sv
module tagdir_match
  import tagdir_pkg::*;
#(
  parameter int WAYS   = 4,
  parameter int ADDR_W = 32,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [ADDR_W-1:0]            addr,
  input  logic [WAYS-1:0]              way_valid,
  input  logic [WAYS-1:0][2:0]         way_perm,
  input  logic [WAYS-1:0][ADDR_W-1:0]  way_tag,
  output logic [WAYS-1:0]              hit_vec,
  output logic                         hit_any,
  output logic [WAY_W-1:0]             hit_way,
  output logic                         same_any,
  output logic [WAYS-1:0]              free_vec,
  output logic                         free_any,
  output logic [WAY_W-1:0]             free_way
);
  logic [WAYS-1:0] same_vec;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      same_vec[w] = way_valid[w] && (way_tag[w] == addr);
      hit_vec[w]  = same_vec[w] && (way_perm[w] != PERM_NP);
      free_vec[w] = !way_valid[w] || (way_perm[w] == PERM_NP);
    end
    hit_way  = '0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w])  hit_way  = WAY_W'(w);
      if (free_vec[w]) free_way = WAY_W'(w);
    end
  end

  assign hit_any  = |hit_vec;
  assign same_any = |same_vec;
  assign free_any = |free_vec;
endmodule

// File: rtl/tagdir_top.sv
module tagdir_top
  import tagdir_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CACHE_BYTES = 1024,
  parameter int WAYS        = 4,
  parameter int LINE_BYTES  = 16,
  parameter int INDEX_LSB   = 4,
  parameter int CTX_W       = 4,
  localparam int SETS   = CACHE_BYTES / WAYS / LINE_BYTES,
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int SLOT_W = SET_W + WAY_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [1:0]        cmd_req,
  input  logic [2:0]        cmd_perm,
  input  logic [CTX_W-1:0]  cmd_ctx,
  input  logic              cmd_touch,
  input  logic [SLOT_W-1:0] cmd_slot,
  output logic              rsp_valid,
  output logic              rsp_ok,
  output logic [WAY_W-1:0]  rsp_way,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              err
);
  logic [SET_W-1:0]            set_idx;
  logic                        misaligned;
  logic [WAYS-1:0]             way_valid;
  logic [WAYS-1:0][2:0]        way_perm;
  logic [WAYS-1:0][ADDR_W-1:0] way_tag;
  logic [WAYS-1:0][CTX_W-1:0]  way_lock;
  logic                        slot_valid;
  logic [2:0]                  slot_perm;
  logic [ADDR_W-1:0]           slot_tag;
  logic [WAYS-1:0]             hit_vec, free_vec;
  logic                        hit_any, same_any, free_any;
  logic [WAY_W-1:0]            hit_way, free_way, victim_way;

  logic                        fire, viol, ok_c;
  logic                        fill_c, drop_c, perm_c, lock_c, touch_c;
  logic                        fill_en, drop_en, perm_en, lock_en, touch_en;
  logic [WAY_W-1:0]            way_c, touch_way;
  logic [ADDR_W-1:0]           addr_c;
  logic [CTX_W-1:0]            lock_val;

  assign set_idx    = cmd_addr[INDEX_LSB +: SET_W];
  assign misaligned = |cmd_addr[OFF_W-1:0];
  assign fire       = cmd_valid && (cmd_op != OP_NOP);

  tagdir_store #(.SETS(SETS), .WAYS(WAYS), .ADDR_W(ADDR_W), .CTX_W(CTX_W)) u_store (
    .clk(clk), .rst(rst), .set_idx(set_idx),
    .fill_en(fill_en), .drop_en(drop_en), .perm_en(perm_en), .lock_en(lock_en),
    .wr_way(way_c), .fill_addr(cmd_addr), .perm_val(cmd_perm), .lock_val(lock_val),
    .way_valid(way_valid), .way_perm(way_perm), .way_tag(way_tag), .way_lock(way_lock),
    .slot_set(cmd_slot[SLOT_W-1:WAY_W]), .slot_way(cmd_slot[WAY_W-1:0]),
    .slot_valid(slot_valid), .slot_perm(slot_perm), .slot_tag(slot_tag)
  );

  tagdir_match #(.WAYS(WAYS), .ADDR_W(ADDR_W)) u_match (
    .addr(cmd_addr), .way_valid(way_valid), .way_perm(way_perm), .way_tag(way_tag),
    .hit_vec(hit_vec), .hit_any(hit_any), .hit_way(hit_way), .same_any(same_any),
    .free_vec(free_vec), .free_any(free_any), .free_way(free_way)
  );

  tagdir_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk(clk), .rst(rst), .set_idx(set_idx),
    .touch_en(touch_en), .touch_way(touch_way),
    .empty_vec(~way_valid), .victim_way(victim_way)
  );

  always_comb begin
    viol      = 1'b0;
    ok_c      = 1'b0;
    fill_c    = 1'b0;
    drop_c    = 1'b0;
    perm_c    = 1'b0;
    lock_c    = 1'b0;
    touch_c   = 1'b0;
    way_c     = hit_way;
    touch_way = hit_way;
    addr_c    = '0;
    lock_val  = {CTX_W{1'b1}};
    case (cmd_op)
      OP_NOP: ;
      OP_LOOKUP: begin
        viol = misaligned;
        ok_c = hit_any;
      end
      OP_ACCESS: begin
        viol    = misaligned;
        touch_c = hit_any;
        ok_c    = hit_any && ((way_perm[hit_way] == PERM_RW) ||
                  ((way_perm[hit_way] == PERM_RO) &&
                   (cmd_req == REQ_LOAD || cmd_req == REQ_FETCH)));
      end
      OP_AVAIL: begin
        viol = misaligned;
        ok_c = same_any || free_any;
      end
      OP_ALLOC: begin
        viol      = misaligned || hit_any || !free_any;
        way_c     = free_way;
        touch_way = free_way;
        fill_c    = 1'b1;
        touch_c   = cmd_touch;
        ok_c      = 1'b1;
      end
      OP_DEALLOC: begin
        viol   = misaligned || !hit_any;
        drop_c = 1'b1;
        ok_c   = 1'b1;
      end
      OP_PROBE: begin
        viol   = misaligned || same_any || free_any;
        way_c  = victim_way;
        addr_c = way_tag[victim_way];
        ok_c   = 1'b1;
      end
      OP_SETPERM: begin
        viol   = misaligned || !hit_any || (cmd_perm > PERM_RW);
        perm_c = 1'b1;
        ok_c   = 1'b1;
      end
      OP_LOCKSET: begin
        viol     = misaligned || !hit_any;
        lock_c   = 1'b1;
        lock_val = cmd_ctx;
        ok_c     = 1'b1;
      end
      OP_LOCKCLR: begin
        viol   = misaligned || !hit_any;
        lock_c = 1'b1;
        ok_c   = 1'b1;
      end
      OP_LOCKTEST: begin
        viol = misaligned || !hit_any;
        ok_c = (way_lock[hit_way] == cmd_ctx);
      end
      OP_READSLOT: begin
        way_c  = cmd_slot[WAY_W-1:0];
        ok_c   = slot_valid && (slot_perm != PERM_INV) && (slot_perm != PERM_NP);
        addr_c = ok_c ? slot_tag : '0;
      end
      default: viol = 1'b1;
    endcase
  end

  assign fill_en  = cmd_valid && fill_c  && !viol;
  assign drop_en  = cmd_valid && drop_c  && !viol;
  assign perm_en  = cmd_valid && perm_c  && !viol;
  assign lock_en  = cmd_valid && lock_c  && !viol;
  assign touch_en = cmd_valid && touch_c && !viol;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_way   <= '0;
      rsp_addr  <= '0;
      err       <= 1'b0;
    end else begin
      rsp_valid <= fire;
      if (fire) begin
        rsp_ok   <= ok_c && !viol;
        rsp_way  <= way_c;
        rsp_addr <= viol ? '0 : addr_c;
        if (viol) err <= 1'b1;
      end
    end
  end

  // R3: at most one present way holds any given address
  p_match_unique_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

  // R12: the error flag never clears without reset
  p_err_sticky_r12: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  // R12: a violating command is answered with failure and a set flag
  p_viol_fails_r12: assert property (@(posedge clk) disable iff (rst)
    (fire && viol) |=> (rsp_valid && !rsp_ok && err));
endmodule

// File: tb/tagdir_top_bench.sv
`timescale 1ns/1ps
module tagdir_top_bench;
  import tagdir_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_op = '0;
  logic [31:0] cmd_addr = '0;
  logic [1:0]  cmd_req = '0;
  logic [2:0]  cmd_perm = '0;
  logic [3:0]  cmd_ctx = '0;
  logic        cmd_touch = 1'b0;
  logic [5:0]  cmd_slot = '0;
  logic        rsp_valid, rsp_ok, err;
  logic [1:0]  rsp_way;
  logic [31:0] rsp_addr;

  always #2 clk = ~clk;

  tagdir_top u_tagdir_top (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_req(cmd_req), .cmd_perm(cmd_perm), .cmd_ctx(cmd_ctx), .cmd_touch(cmd_touch),
    .cmd_slot(cmd_slot), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_way(rsp_way),
    .rsp_addr(rsp_addr), .err(err)
  );

  typedef struct {
    logic        ok;
    logic        chk_way;
    logic [1:0]  way;
    logic        chk_addr;
    logic [31:0] addr;
    logic        err;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 0;
  logic err_exp = 1'b0;
  logic [1:0] n_req   = '0;
  logic [2:0] n_perm  = '0;
  logic [3:0] n_ctx   = '0;
  logic       n_touch = 1'b0;
  logic [5:0] n_slot  = '0;

  function automatic logic [31:0] la(int s, int t);
    return (32'(t) << 8) | (32'(s) << 4);
  endfunction

  task automatic send(input logic [3:0] op, input logic [31:0] a, input logic eok,
                      input logic cw, input logic [1:0] ew, input logic ca,
                      input logic [31:0] ea, input string tag);
    exp_t e;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_req = n_req; cmd_perm = n_perm;
    cmd_ctx = n_ctx; cmd_touch = n_touch; cmd_slot = n_slot;
    e.ok = eok; e.chk_way = cw; e.way = ew; e.chk_addr = ca; e.addr = ea;
    e.err = err_exp; e.tag = tag;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      n_tests++;
      if (q.size() == 0) begin
        n_fail++;
        $display("FAIL R13: response with none expected, ok=%0d expected none", rsp_ok);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (rsp_ok !== e.ok || err !== e.err ||
            (e.chk_way && rsp_way !== e.way) || (e.chk_addr && rsp_addr !== e.addr)) begin
          n_fail++;
          $display("FAIL %s: ok=%0d way=%0d addr=%h err=%0d expected ok=%0d way=%0d addr=%h err=%0d",
                   e.tag, rsp_ok, rsp_way, rsp_addr, err, e.ok, e.way, e.addr, e.err);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    n_tests++;
    if (rsp_valid !== 1'b0 || err !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: rsp_valid=%0d err=%0d expected 0 0", rsp_valid, err);
    end
    // R1 reset state
    send(OP_LOOKUP, la(1,1), 0, 0, 0, 0, 0, "R1");
    send(OP_AVAIL,  la(1,1), 1, 0, 0, 0, 0, "R1");
    // R7 fill lowest free way
    n_touch = 1; send(OP_ALLOC, la(1,1), 1, 1, 0, 0, 0, "R7");
    send(OP_ALLOC, la(1,2), 1, 1, 1, 0, 0, "R7");
    n_touch = 0; send(OP_ALLOC, la(1,3), 1, 1, 2, 0, 0, "R7");
    n_touch = 1; send(OP_ALLOC, la(1,4), 1, 1, 3, 0, 0, "R7");
    n_touch = 0;
    send(OP_LOOKUP, la(1,3), 1, 1, 2, 0, 0, "R3");
    // R4 permission-qualified grants
    n_req = REQ_LOAD; send(OP_ACCESS, la(1,1), 0, 1, 0, 0, 0, "R4");
    n_perm = PERM_RO; send(OP_SETPERM, la(1,1), 1, 0, 0, 0, 0, "R10");
    send(OP_ACCESS, la(1,1), 1, 1, 0, 0, 0, "R4");
    n_req = REQ_FETCH; send(OP_ACCESS, la(1,1), 1, 0, 0, 0, 0, "R4");
    n_req = REQ_STORE; send(OP_ACCESS, la(1,1), 0, 0, 0, 0, 0, "R4");
    n_perm = PERM_RW; send(OP_SETPERM, la(1,2), 1, 0, 0, 0, 0, "R10");
    send(OP_ACCESS, la(1,2), 1, 1, 1, 0, 0, "R4");
    n_req = REQ_ATOMIC; send(OP_ACCESS, la(1,2), 1, 0, 0, 0, 0, "R4");
    n_perm = PERM_BSY; send(OP_SETPERM, la(1,3), 1, 0, 0, 0, 0, "R10");
    n_req = REQ_LOAD; send(OP_ACCESS, la(1,3), 0, 1, 2, 0, 0, "R5");
    // R6 availability
    send(OP_AVAIL, la(1,5), 0, 0, 0, 0, 0, "R6");
    send(OP_AVAIL, la(1,2), 1, 0, 0, 0, 0, "R6");
    // R8 victim follows touches (R5: busy access still refreshed way 2)
    send(OP_PROBE, la(1,5), 1, 1, 3, 1, la(1,4), "R8");
    n_req = REQ_STORE; send(OP_ACCESS, la(1,4), 0, 1, 3, 0, 0, "R5");
    send(OP_PROBE, la(1,5), 1, 1, 0, 1, la(1,1), "R8");
    // R9 locks
    n_ctx = 5; send(OP_LOCKSET, la(1,2), 1, 0, 0, 0, 0, "R9");
    send(OP_LOCKTEST, la(1,2), 1, 0, 0, 0, 0, "R9");
    n_ctx = 6; send(OP_LOCKTEST, la(1,2), 0, 0, 0, 0, 0, "R9");
    send(OP_LOCKCLR, la(1,2), 1, 0, 0, 0, 0, "R9");
    n_ctx = 5; send(OP_LOCKTEST, la(1,2), 0, 0, 0, 0, 0, "R9");
    // R11 slot reads
    n_slot = 6'd4; send(OP_READSLOT, 0, 1, 0, 0, 1, la(1,1), "R11");
    n_slot = 6'd5; send(OP_READSLOT, 0, 1, 0, 0, 1, la(1,2), "R11");
    n_slot = 6'd6; send(OP_READSLOT, 0, 1, 0, 0, 1, la(1,3), "R11");
    n_slot = 6'd7; send(OP_READSLOT, 0, 0, 0, 0, 1, 0, "R11");
    n_slot = 6'd0; send(OP_READSLOT, 0, 0, 0, 0, 1, 0, "R11");
    // R10 release and reuse; R7 lock reset on allocation
    n_ctx = 7; send(OP_LOCKSET, la(1,4), 1, 0, 0, 0, 0, "R9");
    send(OP_DEALLOC, la(1,4), 1, 0, 0, 0, 0, "R10");
    send(OP_LOOKUP, la(1,4), 0, 0, 0, 0, 0, "R10");
    send(OP_AVAIL, la(1,5), 1, 0, 0, 0, 0, "R10");
    send(OP_ALLOC, la(1,5), 1, 1, 3, 0, 0, "R10");
    send(OP_LOCKTEST, la(1,5), 0, 0, 0, 0, 0, "R7");
    n_perm = PERM_NP; send(OP_SETPERM, la(1,1), 1, 0, 0, 0, 0, "R10");
    send(OP_LOOKUP, la(1,1), 0, 0, 0, 0, 0, "R3");
    send(OP_ALLOC, la(1,6), 1, 1, 0, 0, 0, "R7");
    // R2 index isolation
    send(OP_ALLOC, la(2,1), 1, 1, 0, 0, 0, "R2");
    send(OP_LOOKUP, la(2,1), 1, 1, 0, 0, 0, "R2");
    send(OP_LOOKUP, la(3,1), 0, 0, 0, 0, 0, "R2");
    // R12 errors
    err_exp = 1'b1;
    send(OP_DEALLOC, la(3,9), 0, 0, 0, 0, 0, "R12");
    send(OP_ALLOC, la(1,2), 0, 0, 0, 0, 0, "R12");
    send(OP_LOOKUP, la(1,2), 1, 1, 1, 0, 0, "R12");
    send(OP_LOOKUP, la(1,2) | 32'h4, 0, 0, 0, 0, 0, "R12");
    send(OP_PROBE, la(1,5), 0, 0, 0, 0, 0, "R12");
    send(4'd13, la(1,2), 0, 0, 0, 0, 0, "R12");
    n_perm = 3'd6; send(OP_SETPERM, la(1,2), 0, 0, 0, 0, 0, "R12");
    n_req = REQ_STORE; send(OP_ACCESS, la(1,2), 1, 1, 1, 0, 0, "R12");
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = OP_NOP;
    repeat (3) @(negedge clk);
    n_tests++;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL R13: %0d responses missing, expected 0", q.size());
    end
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule